// File: doc/BRIEF.md
# Two/Four-Level Receive Symbol Decision and Output Steering

This block turns each signed, equalized receive sample into a two-bit line symbol made of a sign bit and a magnitude bit. In four-level mode it compares the sample against a programmable negative threshold, zero, and a programmable positive threshold, so it recovers both sign and magnitude. In two-level mode only the zero comparison is used, and every symbol lands on one of the two outer levels.

An external peak-detection stage may supply its own symbol decision together with a qualifying flag. When the override is enabled and that flag is high, the external decision replaces the slicer's decision. The block then steers three registered outputs:
- The DFE/timing-recovery output and the transmit detector loopback output carry either the local decision or an externally supplied scrambler/descrambler symbol.
- The channel-unit receive output has its own selector. It can follow the DFE path, the transmit loopback symbol, or the scrambler symbol, or it can drive zero.

All three outputs update only on a sample strobe, one clock after that strobe.

Top module: `sym_slicer_top`

## Requirements
- R1: While `rst` is high at a clock edge, all three symbol outputs become 2'b00 on that edge.
- R2: With `four_level`=1, a sample at or above `lvl_high` yields 2'b10 (+3). A sample below `lvl_high` and at or above 0 yields 2'b11 (+1). A sample below 0 and at or above `lvl_low` yields 2'b01 (-1). A sample below `lvl_low` yields 2'b00 (-3). Bit 1 is the sign (1 = positive) and bit 0 is the magnitude (1 = inner level). All comparisons are signed.
- R3: With `four_level`=0, the magnitude bit is 0. The sign bit is 1 when the sample is 0 or greater and 0 otherwise, so the only possible symbols are 2'b10 and 2'b00.
- R4: When `peak_en`=1 and `pk_valid`=1, the decision equals `pk_sym`.
- R5: When `peak_en`=0 or `pk_valid`=0, `pk_sym` has no effect and the slicer decision is used.
- R6: `dfe_sym` and `lb_sym` both carry `scr_sym` when `scr_to_dfe`=1, and the decision when `scr_to_dfe`=0.
- R7: `rx_sel`=2'b00 makes `rx_sym` equal to the value loaded into `dfe_sym`.
- R8: `rx_sel`=2'b01 makes `rx_sym` equal to `tx_lb_sym`.
- R9: `rx_sel`=2'b10 makes `rx_sym` equal to `scr_sym`.
- R10: `rx_sel`=2'b11 makes `rx_sym` equal to 2'b00.
- R11: Outputs load on a clock edge where `smp_valid`=1. They hold their value on any edge where it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Sample strobe; outputs load on this cycle |
| smp_data | input | SMP_W | Signed equalized sample |
| four_level | input | 1 | 1 = four-level, 0 = two-level decisions |
| lvl_low | input | SMP_W | Signed negative inner/outer threshold |
| lvl_high | input | SMP_W | Signed positive inner/outer threshold |
| peak_en | input | 1 | Enable for the external peak decision override |
| pk_valid | input | 1 | External peak criteria met |
| pk_sym | input | 2 | External peak decision symbol |
| scr_to_dfe | input | 1 | Select scrambler symbol for DFE and loopback outputs |
| rx_sel | input | 2 | Receive output source select |
| scr_sym | input | 2 | Scrambler/descrambler symbol |
| tx_lb_sym | input | 2 | Transmit loopback symbol |
| rx_sym | output | 2 | Registered channel-unit receive symbol |
| dfe_sym | output | 2 | Registered DFE/timing-recovery symbol |
| lb_sym | output | 2 | Registered transmit detector loopback symbol |

## Verification
Every output is due exactly one clock edge after the strobe that carries its inputs. Between those inputs and the output there is one register and nothing else. The bench therefore drives a sample and its controls on a falling edge with the strobe high, lets one rising edge pass, and compares all three outputs at the next falling edge against values its own functions compute. For the hold behaviour, the bench changes every input with the strobe low for several edges and expects the previous outputs to remain unchanged.

// File: rtl/sym_slicer_pkg.sv
package sym_slicer_pkg;

  typedef struct packed {
    logic sgn;
    logic mag;
  } sym_t;

  typedef enum logic [1:0] {
    RX_FOLLOW_DFE = 2'b00,
    RX_TX_LOOP    = 2'b01,
    RX_SCRAMBLER  = 2'b10,
    RX_RESERVED   = 2'b11
  } rx_sel_e;

  localparam sym_t SYM_ZERO = '{sgn: 1'b0, mag: 1'b0};

endpackage

// File: rtl/sym_threshold.sv
module sym_threshold
  import sym_slicer_pkg::*;
#(
  parameter int SMP_W = 12
) (
  input  logic signed [SMP_W-1:0] smp,
  input  logic signed [SMP_W-1:0] thr_low,
  input  logic signed [SMP_W-1:0] thr_high,
  input  logic                    four_level,
  output sym_t                    slice
);

  localparam logic signed [SMP_W-1:0] ZERO_THR = '0;

  logic at_or_above_zero;
  logic at_or_above_high;
  logic at_or_above_low;

  always_comb begin
    at_or_above_zero = (smp >= ZERO_THR);
    at_or_above_high = (smp >= thr_high);
    at_or_above_low  = (smp >= thr_low);
  end

  always_comb begin
    slice.sgn = at_or_above_zero;
    if (!four_level) begin
      slice.mag = 1'b0;
    end else if (at_or_above_zero) begin
      slice.mag = !at_or_above_high;
    end else begin
      slice.mag = at_or_above_low;
    end
  end

endmodule

// File: rtl/sym_pick.sv
module sym_pick
  import sym_slicer_pkg::*;
(
  input  sym_t slice,
  input  sym_t pk_dec,
  input  logic peak_en,
  input  logic pk_valid,
  output sym_t decision
);

  always_comb begin
    if (peak_en && pk_valid) begin
      decision = pk_dec;
    end else begin
      decision = slice;
    end
  end

endmodule

// File: rtl/sym_steer.sv
module sym_steer
  import sym_slicer_pkg::*;
#(
  parameter int N_LB_COPIES = 1
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    load,
  input  sym_t    decision,
  input  sym_t    scr,
  input  sym_t    tx_lb,
  input  logic    scr_to_dfe,
  input  rx_sel_e rx_sel,
  output sym_t    rx_q,
  output sym_t    dfe_q,
  output sym_t    lb_q
);

  sym_t dfe_src;
  sym_t rx_src;
  sym_t lb_stage [N_LB_COPIES];

  always_comb begin
    dfe_src = scr_to_dfe ? scr : decision;
    unique case (rx_sel)
      RX_FOLLOW_DFE: rx_src = dfe_src;
      RX_TX_LOOP:    rx_src = tx_lb;
      RX_SCRAMBLER:  rx_src = scr;
      default:       rx_src = SYM_ZERO;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_q  <= SYM_ZERO;
      dfe_q <= SYM_ZERO;
    end else if (load) begin
      rx_q  <= rx_src;
      dfe_q <= dfe_src;
    end
  end

  genvar gi;
  generate
    for (gi = 0; gi < N_LB_COPIES; gi++) begin : g_lb
      always_ff @(posedge clk) begin
        if (rst) begin
          lb_stage[gi] <= SYM_ZERO;
        end else if (load) begin
          lb_stage[gi] <= dfe_src;
        end
      end
    end
  endgenerate

  assign lb_q = lb_stage[0];

  a_r11_hold: assert property (@(posedge clk) disable iff (rst)
    !load |=> ($stable(rx_q) && $stable(dfe_q) && $stable(lb_q)));

  a_r10_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    (load && rx_sel == RX_RESERVED) |=> (rx_q == SYM_ZERO));

  a_r6_lb_matches_dfe: assert property (@(posedge clk) disable iff (rst)
    load |=> (lb_q == dfe_q));

  a_r8_tx_loop: assert property (@(posedge clk) disable iff (rst)
    (load && rx_sel == RX_TX_LOOP) |=> (rx_q == $past(tx_lb)));

endmodule

// File: rtl/sym_slicer_top.sv
module sym_slicer_top
  import sym_slicer_pkg::*;
#(
  parameter int SMP_W = 12
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    smp_valid,
  input  logic signed [SMP_W-1:0] smp_data,
  input  logic                    four_level,
  input  logic signed [SMP_W-1:0] lvl_low,
  input  logic signed [SMP_W-1:0] lvl_high,
  input  logic                    peak_en,
  input  logic                    pk_valid,
  input  logic [1:0]              pk_sym,
  input  logic                    scr_to_dfe,
  input  logic [1:0]              rx_sel,
  input  logic [1:0]              scr_sym,
  input  logic [1:0]              tx_lb_sym,
  output logic [1:0]              rx_sym,
  output logic [1:0]              dfe_sym,
  output logic [1:0]              lb_sym
);

  sym_t slice;
  sym_t decision;
  sym_t rx_q;
  sym_t dfe_q;
  sym_t lb_q;

  sym_threshold #(.SMP_W(SMP_W)) u_thr (
    .smp        (smp_data),
    .thr_low    (lvl_low),
    .thr_high   (lvl_high),
    .four_level (four_level),
    .slice      (slice)
  );

  sym_pick u_pick (
    .slice    (slice),
    .pk_dec   (sym_t'(pk_sym)),
    .peak_en  (peak_en),
    .pk_valid (pk_valid),
    .decision (decision)
  );

  sym_steer #(.N_LB_COPIES(1)) u_steer (
    .clk        (clk),
    .rst        (rst),
    .load       (smp_valid),
    .decision   (decision),
    .scr        (sym_t'(scr_sym)),
    .tx_lb      (sym_t'(tx_lb_sym)),
    .scr_to_dfe (scr_to_dfe),
    .rx_sel     (rx_sel_e'(rx_sel)),
    .rx_q       (rx_q),
    .dfe_q      (dfe_q),
    .lb_q       (lb_q)
  );

  assign rx_sym  = rx_q;
  assign dfe_sym = dfe_q;
  assign lb_sym  = lb_q;

  a_r1_reset_zero: assert property (@(posedge clk)
    rst |=> (rx_sym == 2'b00 && dfe_sym == 2'b00 && lb_sym == 2'b00));

  a_r3_two_level_outer: assert property (@(posedge clk) disable iff (rst)
    (smp_valid && !four_level && !scr_to_dfe && !(peak_en && pk_valid))
      |=> (dfe_sym[0] == 1'b0));

  a_r4_peak_override: assert property (@(posedge clk) disable iff (rst)
    (smp_valid && peak_en && pk_valid && !scr_to_dfe)
      |=> (dfe_sym == $past(pk_sym)));

  a_r7_follow_dfe: assert property (@(posedge clk) disable iff (rst)
    (smp_valid && rx_sel == 2'b00) |=> (rx_sym == dfe_sym));

  a_r9_scrambler: assert property (@(posedge clk) disable iff (rst)
    (smp_valid && rx_sel == 2'b10) |=> (rx_sym == $past(scr_sym)));

endmodule

// File: tb/sym_slicer_top_tb.sv
module sym_slicer_top_tb;

  localparam int W = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic smp_valid = 1'b0;
  logic signed [W-1:0] smp_data = '0;
  logic four_level = 1'b1;
  logic signed [W-1:0] lvl_low = -12'sd400;
  logic signed [W-1:0] lvl_high = 12'sd400;
  logic peak_en = 1'b0, pk_valid = 1'b0, scr_to_dfe = 1'b0;
  logic [1:0] pk_sym = '0, rx_sel = '0, scr_sym = '0, tx_lb_sym = '0;
  logic [1:0] rx_sym, dfe_sym, lb_sym;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sym_slicer_top #(.SMP_W(W)) u_dut (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
    .four_level(four_level), .lvl_low(lvl_low), .lvl_high(lvl_high),
    .peak_en(peak_en), .pk_valid(pk_valid), .pk_sym(pk_sym),
    .scr_to_dfe(scr_to_dfe), .rx_sel(rx_sel), .scr_sym(scr_sym),
    .tx_lb_sym(tx_lb_sym), .rx_sym(rx_sym), .dfe_sym(dfe_sym), .lb_sym(lb_sym)
  );

  function automatic logic [1:0] ref_slice(input logic signed [W-1:0] s,
      input logic four, input logic signed [W-1:0] lo, input logic signed [W-1:0] hi);
    if (!four) return (s >= 0) ? 2'b10 : 2'b00;
    if (s >= hi) return 2'b10;
    if (s >= 0)  return 2'b11;
    if (s >= lo) return 2'b01;
    return 2'b00;
  endfunction

  function automatic logic [1:0] ref_dfe(input logic [1:0] sl);
    logic [1:0] d;
    d = (peak_en && pk_valid) ? pk_sym : sl;
    return scr_to_dfe ? scr_sym : d;
  endfunction

  function automatic logic [1:0] ref_rx(input logic [1:0] dfe);
    case (rx_sel)
      2'b00:   return dfe;
      2'b01:   return tx_lb_sym;
      2'b10:   return scr_sym;
      default: return 2'b00;
    endcase
  endfunction

  task automatic chk(input string req, input string what, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic apply_and_check(input string req);
    logic [1:0] e_dfe, e_rx;
    e_dfe = ref_dfe(ref_slice(smp_data, four_level, lvl_low, lvl_high));
    e_rx = ref_rx(e_dfe);
    smp_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    smp_valid = 1'b0;
    chk(req, "dfe_sym", dfe_sym, e_dfe);
    chk(req, "lb_sym", lb_sym, e_dfe);
    chk(req, "rx_sym", rx_sym, e_rx);
  endtask

  task automatic plain_cfg();
    peak_en = 0; pk_valid = 0; scr_to_dfe = 0; rx_sel = 2'b00;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    int seed_init;
    logic [1:0] h_rx, h_dfe, h_lb;
    seed_init = $urandom(32'd20240611);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "rx_sym reset", rx_sym, 2'b00);
    chk("R1", "dfe_sym reset", dfe_sym, 2'b00);
    chk("R1", "lb_sym reset", lb_sym, 2'b00);
    rst = 1'b0;

    // R2: four-level thresholds and ties toward positive
    plain_cfg(); four_level = 1;
    smp_data = lvl_high;        apply_and_check("R2 at high");
    smp_data = lvl_high - 1;    apply_and_check("R2 below high");
    smp_data = 0;               apply_and_check("R2 at zero");
    smp_data = -1;              apply_and_check("R2 minus one");
    smp_data = lvl_low;         apply_and_check("R2 at low");
    smp_data = lvl_low - 1;     apply_and_check("R2 below low");
    smp_data = 12'sh7FF;        apply_and_check("R2 max");
    smp_data = 12'sh800;        apply_and_check("R2 min");

    // R3: two-level
    four_level = 0;
    smp_data = 0;               apply_and_check("R3 zero");
    smp_data = -1;              apply_and_check("R3 minus one");
    smp_data = 12'sd5;          apply_and_check("R3 inner positive");
    smp_data = -12'sd5;         apply_and_check("R3 inner negative");

    // R4 / R5: peak override
    four_level = 1; smp_data = 12'sd10;
    peak_en = 1; pk_valid = 1; pk_sym = 2'b00; apply_and_check("R4 override");
    peak_en = 1; pk_valid = 0; pk_sym = 2'b00; apply_and_check("R5 not valid");
    peak_en = 0; pk_valid = 1; pk_sym = 2'b01; apply_and_check("R5 disabled");

    // R6 .. R10: steering
    plain_cfg(); smp_data = -12'sd900; scr_sym = 2'b11; tx_lb_sym = 2'b01;
    scr_to_dfe = 1; apply_and_check("R6 scrambler to dfe");
    scr_to_dfe = 0; apply_and_check("R6 decision to dfe");
    rx_sel = 2'b00; scr_to_dfe = 1; apply_and_check("R7 follow dfe");
    rx_sel = 2'b01; apply_and_check("R8 tx loopback");
    rx_sel = 2'b10; scr_to_dfe = 0; apply_and_check("R9 scrambler");
    rx_sel = 2'b11; apply_and_check("R10 reserved");

    // R11: hold with strobe low
    rx_sel = 2'b01; tx_lb_sym = 2'b10; apply_and_check("R11 setup");
    h_rx = rx_sym; h_dfe = dfe_sym; h_lb = lb_sym;
    smp_valid = 0; smp_data = 12'sd1500; tx_lb_sym = 2'b01; scr_sym = 2'b00;
    scr_to_dfe = 1; rx_sel = 2'b10;
    repeat (4) @(negedge clk);
    chk("R11", "rx_sym hold", rx_sym, h_rx);
    chk("R11", "dfe_sym hold", dfe_sym, h_dfe);
    chk("R11", "lb_sym hold", lb_sym, h_lb);

    // Random mix over R2..R10
    for (int i = 0; i < 400; i++) begin
      four_level = $urandom_range(0, 1);
      lvl_high = W'($urandom_range(50, 1500));
      lvl_low = -W'($urandom_range(50, 1500));
      smp_data = W'($urandom);
      peak_en = ($urandom_range(0, 3) == 0);
      pk_valid = $urandom_range(0, 1);
      pk_sym = 2'($urandom);
      scr_to_dfe = ($urandom_range(0, 3) == 0);
      rx_sel = 2'($urandom);
      scr_sym = 2'($urandom);
      tx_lb_sym = 2'($urandom);
      apply_and_check("R2-mix random");
    end

    // R1: reset mid-run
    rst = 1; @(posedge clk); @(negedge clk); rst = 0;
    chk("R1", "rx_sym mid reset", rx_sym, 2'b00);
    chk("R1", "dfe_sym mid reset", dfe_sym, 2'b00);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule